// File: doc/BRIEF.md
# Row-Rotating Symbol Interleaver

This block reorders the modulation symbols of one uplink subframe before DFT spreading, so that the symbols of each code block are spread across both time and frequency. Symbols arrive in code-block order, with every symbol of block 0 before any symbol of block 1. They are stored frequency first: all subcarrier positions of one SC-FDMA symbol are filled before the next SC-FDMA symbol starts. The block then rotates each subcarrier row cyclically by a row-specific amount and streams the array out one SC-FDMA symbol at a time. Each output symbol carries its SC-FDMA symbol index and its subcarrier index.

The rotation amounts come from one of two built-in tables. The table in use is chosen by whether the subframe contains a sounding symbol, because that choice also sets the number of SC-FDMA symbols: 12 without a sounding symbol and 11 with one. The rotation is never done by moving data. The read address is offset instead, so one storage array of MSC x 12 words serves both cases. A subframe first fills the array (input handshake open) and then drains it (input handshake closed). A one-cycle completion pulse ends the drain.

Top module: `row_shift_ilv`

## Requirements
- R1: Input symbol k of a subframe is placed in row k mod MSC, column k / MSC.
- R2: in_ready is 1 during the fill phase and 0 during the drain phase. in_valid has no effect while in_ready is 0. The fill phase accepts exactly MSC x L symbols.
- R3: sounding_present is sampled only when the first symbol of a subframe is accepted. It selects L = 12 (value 0) or L = 11 (value 1) for the whole subframe. Later changes of sounding_present have no effect until the next subframe.
- R4: With L = 12, row r rotates by entry r mod 12 of [0 8 2 6 1 7 3 11 5 9 4 10].
- R5: With L = 11, row r rotates by entry r mod 11 of [0 7 2 6 1 8 5 10 3 9 4].
- R6: Output runs column by column: out_sym rises from 0 to L-1, and within each column out_sc rises from 0 to MSC-1. out_valid first rises two cycles after the last input is accepted.
- R7: The output at row r, column c is the symbol stored at row r, column (c - P_r) mod L.
- R8: While out_valid is 1 and out_ready is 0, out_data, out_sym and out_sc hold their values.
- R9: done is high for exactly one cycle, in the cycle after the last output handshake. In that same cycle in_ready is 1 again.
- R10: During and after reset, in_ready is 1, out_valid is 0 and done is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sounding_present | input | 1 | 1 selects the 11-column layout for the subframe |
| in_valid | input | 1 | Input symbol valid |
| in_ready | output | 1 | High during the fill phase |
| in_data | input | DATA_W | Input modulation symbol |
| out_valid | output | 1 | Output symbol valid |
| out_ready | input | 1 | Downstream accepts the output symbol |
| out_data | output | DATA_W | Interleaved symbol |
| out_sym | output | 4 | SC-FDMA symbol index of the output |
| out_sc | output | SC_W | Subcarrier index of the output |
| done | output | 1 | One-cycle pulse after the last output |

## Verification
The bench builds the block with MSC = 14 and DATA_W = 12. Because 14 exceeds both frame lengths, the rotation table wraps: rows 12 and 13 reuse the first entries of the 12-entry table, and rows 11 to 13 reuse the first entries of the 11-entry table. That makes the periodic row lookup and the modular column arithmetic observable at every wrap. Subframes alternate the two layouts, and the valid and ready patterns are sparse and random. In some subframes sounding_present toggles during the fill, which exercises the stall hold, the closed input during the drain and the subframe-wide latch of the layout choice.

// File: rtl/ilv_pkg.sv
package ilv_pkg;
  localparam int LMAX  = 12;
  localparam int COL_W = 4;

  typedef enum logic {PH_FILL = 1'b0, PH_DRAIN = 1'b1} phase_e;

  // Number of SC-FDMA symbols in the subframe
  function automatic logic [COL_W-1:0] frame_len(input logic snd);
    return snd ? 4'd11 : 4'd12;
  endfunction

  // Rotation amount applied to a row whose index modulo the frame length is idx
  function automatic logic [COL_W-1:0] shift_amt(input logic snd, input logic [COL_W-1:0] idx);
    logic [COL_W-1:0] p;
    p = 4'd0;
    if (!snd) begin
      case (idx)
        4'd1:  p = 4'd8;
        4'd2:  p = 4'd2;
        4'd3:  p = 4'd6;
        4'd4:  p = 4'd1;
        4'd5:  p = 4'd7;
        4'd6:  p = 4'd3;
        4'd7:  p = 4'd11;
        4'd8:  p = 4'd5;
        4'd9:  p = 4'd9;
        4'd10: p = 4'd4;
        4'd11: p = 4'd10;
        default: p = 4'd0;
      endcase
    end else begin
      case (idx)
        4'd1:  p = 4'd7;
        4'd2:  p = 4'd2;
        4'd3:  p = 4'd6;
        4'd4:  p = 4'd1;
        4'd5:  p = 4'd8;
        4'd6:  p = 4'd5;
        4'd7:  p = 4'd10;
        4'd8:  p = 4'd3;
        4'd9:  p = 4'd9;
        4'd10: p = 4'd4;
        default: p = 4'd0;
      endcase
    end
    return p;
  endfunction
endpackage

// File: rtl/ilv_sdp_ram.sv
module ilv_sdp_ram #(
  parameter int DW    = 16,
  parameter int DEPTH = 288,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  // Registered read with enable: the output holds when rd_en is low
  always_ff @(posedge clk) begin
    if (rd_en) rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/ilv_col_map.sv
module ilv_col_map
  import ilv_pkg::*;
(
  input  logic             snd,
  input  logic [COL_W-1:0] col,
  input  logic [COL_W-1:0] rmod,
  output logic [COL_W-1:0] src_col
);
  logic [COL_W:0]   sum;
  logic [COL_W:0]   len_x;
  logic [COL_W-1:0] p;

  // Output column c reads stored column (c - P) mod L
  always_comb begin
    len_x = {1'b0, frame_len(snd)};
    p     = shift_amt(snd, rmod);
    sum   = {1'b0, col} + len_x - {1'b0, p};
    if (sum >= len_x) src_col = COL_W'(sum - len_x);
    else              src_col = sum[COL_W-1:0];
  end
endmodule

// File: rtl/row_shift_ilv.sv
module row_shift_ilv
  import ilv_pkg::*;
#(
  parameter int MSC    = 24,
  parameter int DATA_W = 16
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic                                 sounding_present,
  input  logic                                 in_valid,
  output logic                                 in_ready,
  input  logic [DATA_W-1:0]                    in_data,
  output logic                                 out_valid,
  input  logic                                 out_ready,
  output logic [DATA_W-1:0]                    out_data,
  output logic [COL_W-1:0]                     out_sym,
  output logic [((MSC > 1) ? $clog2(MSC) : 1)-1:0] out_sc,
  output logic                                 done
);
  localparam int DEPTH = MSC * LMAX;
  localparam int AW    = $clog2(DEPTH);
  localparam int SC_W  = (MSC > 1) ? $clog2(MSC) : 1;
  localparam logic [SC_W-1:0] ROW_LAST = SC_W'(MSC - 1);
  localparam logic [AW-1:0]   MSC_A    = AW'(MSC);

  phase_e           phase;
  logic             snd_q, first_q;
  logic             cur_snd;
  logic [COL_W-1:0] cur_len, len_q;

  logic [SC_W-1:0]  wr_row, rd_row;
  logic [COL_W-1:0] wr_col, rd_col, rd_rmod, src_col;
  logic             rd_done_q;
  logic             in_fire, wr_last, rd_last, adv, rd_issue, drain_end;
  logic [AW-1:0]    wr_addr, rd_addr;

  assign in_ready = (phase == PH_FILL);
  assign in_fire  = in_valid && in_ready;
  assign cur_snd  = first_q ? sounding_present : snd_q;
  assign cur_len  = frame_len(cur_snd);
  assign len_q    = frame_len(snd_q);
  assign wr_last  = (wr_row == ROW_LAST) && (wr_col == cur_len - 4'd1);
  assign rd_last  = (rd_row == ROW_LAST) && (rd_col == len_q - 4'd1);
  assign adv       = !out_valid || out_ready;
  assign rd_issue  = (phase == PH_DRAIN) && adv && !rd_done_q;
  assign drain_end = (phase == PH_DRAIN) && adv && rd_done_q;

  assign wr_addr = AW'(wr_col) * MSC_A + AW'(wr_row);
  assign rd_addr = AW'(src_col) * MSC_A + AW'(rd_row);

  ilv_col_map u_col_map (
    .snd     (snd_q),
    .col     (rd_col),
    .rmod    (rd_rmod),
    .src_col (src_col)
  );

  ilv_sdp_ram #(.DW(DATA_W), .DEPTH(DEPTH), .AW(AW)) u_ram (
    .clk     (clk),
    .wr_en   (in_fire),
    .wr_addr (wr_addr),
    .wr_data (in_data),
    .rd_en   (rd_issue),
    .rd_addr (rd_addr),
    .rd_data (out_data)
  );

  // Fill side: frequency-first write order and layout latch
  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= PH_FILL;
      snd_q   <= 1'b0;
      first_q <= 1'b1;
      wr_row  <= '0;
      wr_col  <= '0;
    end else begin
      if (in_fire) begin
        if (first_q) snd_q <= sounding_present;
        first_q <= 1'b0;
        if (wr_last) begin
          phase  <= PH_DRAIN;
          wr_row <= '0;
          wr_col <= '0;
        end else if (wr_row == ROW_LAST) begin
          wr_row <= '0;
          wr_col <= wr_col + 4'd1;
        end else begin
          wr_row <= wr_row + 1'b1;
        end
      end
      if (drain_end) begin
        phase   <= PH_FILL;
        first_q <= 1'b1;
      end
    end
  end

  // Drain side: column-by-column read with registered tags
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_row    <= '0;
      rd_col    <= '0;
      rd_rmod   <= '0;
      rd_done_q <= 1'b0;
      out_valid <= 1'b0;
      out_sym   <= '0;
      out_sc    <= '0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      if (rd_issue) begin
        out_valid <= 1'b1;
        out_sym   <= rd_col;
        out_sc    <= rd_row;
        if (rd_last) rd_done_q <= 1'b1;
        if (rd_row == ROW_LAST) begin
          rd_row  <= '0;
          rd_rmod <= '0;
          rd_col  <= rd_col + 4'd1;
        end else begin
          rd_row  <= rd_row + 1'b1;
          rd_rmod <= (rd_rmod == len_q - 4'd1) ? '0 : rd_rmod + 4'd1;
        end
      end else if (drain_end) begin
        out_valid <= 1'b0;
        done      <= 1'b1;
        rd_row    <= '0;
        rd_col    <= '0;
        rd_rmod   <= '0;
        rd_done_q <= 1'b0;
      end
    end
  end

  // Assertions
  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_sym) && $stable(out_sc)))
    else $error("R8 output changed while stalled");

  p_fill_drain_excl_r2: assert property (@(posedge clk) disable iff (rst)
    in_ready |-> !out_valid)
    else $error("R2 in_ready overlaps out_valid");

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done)
    else $error("R9 done longer than one cycle");

  p_done_after_fire_r9: assert property (@(posedge clk) disable iff (rst)
    done |-> ($past(out_valid && out_ready) && in_ready))
    else $error("R9 done without final handshake");

  p_tag_range_r6: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ((int'(out_sc) < MSC) && (out_sym < len_q)))
    else $error("R6 output tag out of range");

  p_first_output_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid) |-> (out_sym == '0 && out_sc == '0))
    else $error("R6 drain does not start at column 0 row 0");

  p_src_col_range_r7: assert property (@(posedge clk) disable iff (rst)
    rd_issue |-> (src_col < len_q))
    else $error("R7 source column out of range");
endmodule

// File: tb/row_shift_ilv_tb_top.sv
module row_shift_ilv_tb_top;
  localparam int MSC   = 14;
  localparam int DW    = 12;
  localparam int N_MAX = MSC * 12;

  logic          clk, rst, sounding_present, in_valid, in_ready, out_valid, out_ready, done;
  logic [DW-1:0] in_data, out_data;
  logic [3:0]    out_sym;
  logic [3:0]    out_sc;

  row_shift_ilv #(.MSC(MSC), .DATA_W(DW)) dut_i (
    .clk(clk), .rst(rst), .sounding_present(sounding_present),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_sym(out_sym), .out_sc(out_sc), .done(done)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  int tab12 [12] = '{0, 8, 2, 6, 1, 7, 3, 11, 5, 9, 4, 10};
  int tab11 [11] = '{0, 7, 2, 6, 1, 8, 5, 10, 3, 9, 4};
  int inbuf [N_MAX];
  int phase_m = 0, mcnt = 0, ocnt = 0, mlen = 12, data_ctr = 1, frames = 0, cycles = 0;
  bit msnd = 0, exp_done = 0, stall_prev = 0, hung = 0;
  int pin = 100, pout = 100;
  bit cfg_snd = 0, cfg_flip = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One cycle of the reference model: check, drive, then account handshakes
  task automatic step();
    int c, r, p, src, exp_data;
    bit in_fire, out_fire;
    @(negedge clk);
    cycles++;
    chk(in_ready == (phase_m == 0), "R2 in_ready", int'(in_ready), int'(phase_m == 0));
    chk(done == exp_done, "R9 done", int'(done), int'(exp_done));
    chk(out_valid == (phase_m == 2), "R6 out_valid", int'(out_valid), int'(phase_m == 2));
    if (phase_m == 2 && out_valid) begin
      c = ocnt / MSC;
      r = ocnt % MSC;
      p = msnd ? tab11[r % mlen] : tab12[r % mlen];
      src = (c - p + mlen) % mlen;
      exp_data = inbuf[src * MSC + r];  // R1 placement, R7 source column
      chk(int'(out_sym) == c, stall_prev ? "R8 hold sym" : "R6 sym", int'(out_sym), c);
      chk(int'(out_sc) == r, stall_prev ? "R8 hold sc" : "R6 sc", int'(out_sc), r);
      chk(int'(out_data) == exp_data,
          cfg_flip ? "R3 data" : (msnd ? "R5 data" : "R4 data"), int'(out_data), exp_data);
    end
    exp_done = 0;
    // Drive inputs (valid kept random during the drain too: R2 ignore)
    in_valid  = ($urandom_range(99) < pin);
    in_data   = DW'(data_ctr);
    if (phase_m == 0 && mcnt == 0) sounding_present = cfg_snd;
    else if (cfg_flip)             sounding_present = $urandom_range(1);
    out_ready = ($urandom_range(99) < pout);
    in_fire  = in_valid && in_ready;
    out_fire = out_valid && out_ready;
    stall_prev = (phase_m == 2) && out_valid && !out_ready;
    if (phase_m == 0 && in_fire) begin
      if (mcnt == 0) begin
        msnd = sounding_present;
        mlen = msnd ? 11 : 12;
      end
      inbuf[mcnt] = int'(in_data);
      mcnt++;
      data_ctr = (data_ctr * 7 + 13) % 4093;
      if (mcnt == MSC * mlen) begin
        phase_m = 1;
        mcnt = 0;
      end
    end else if (phase_m == 1) begin
      phase_m = 2;
    end else if (phase_m == 2 && out_fire) begin
      ocnt++;
      if (ocnt == MSC * mlen) begin
        phase_m = 0;
        ocnt = 0;
        exp_done = 1;
        frames++;
      end
    end
  endtask

  task automatic run_frame(input bit snd, input int p_in, input int p_out, input bit flip);
    int start;
    cfg_snd = snd; pin = p_in; pout = p_out; cfg_flip = flip;
    start = frames;
    while (frames == start && !hung) begin
      step();
      if (cycles > 100000) hung = 1;
    end
  endtask

  initial begin
    rst = 1'b1; in_valid = 1'b0; in_data = '0; out_ready = 1'b0; sounding_present = 1'b0;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk(in_ready == 1'b1, "R10 in_ready", int'(in_ready), 1);
    chk(out_valid == 1'b0, "R10 out_valid", int'(out_valid), 0);
    chk(done == 1'b0, "R10 done", int'(done), 0);
    rst = 1'b0;
    run_frame(1'b0, 100, 100, 1'b0);
    run_frame(1'b1, 100, 100, 1'b0);
    run_frame(1'b0, 60, 50, 1'b1);
    run_frame(1'b1, 40, 70, 1'b1);
    run_frame(1'b0, 100, 30, 1'b0);
    run_frame(1'b1, 80, 100, 1'b1);
    if (!hung) repeat (4) step();
    if (hung) chk(1'b0, "R6 watchdog", cycles, 100000);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule